// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Unit

This block gathers the interrupt causes of a UART into one interrupt line and an 8-bit identification byte that the host reads to find the most urgent cause. It takes four kinds of cause. The first is a line-status cause, raised by any receive error or break indication. The second is a receive cause, which is either data available or a character timeout. The third is a transmit-holding-register-empty cause. The fourth is a modem-status cause, built from change ("delta") bits that the block captures itself from four modem status pins.

Each cause is latched when its event arrives and is cleared by a specific host access. Reading the line status clears the line cause. Reading the receive buffer clears both receive causes. A write to the holding register clears the transmit cause, and so does a read of the identification byte while that byte reports the transmit cause. Reading the modem status clears all four delta bits. A 4-bit enable word masks each cause from the interrupt line and from the identification byte. A masked cause stays latched, so it is reported as soon as it is enabled. There is no data stream in this block: every pin is a plain control or status signal, and no handshake is involved.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the identification byte is 0x01, the interrupt line is low and the delta bits are 0000. Modem pin levels present during reset produce no delta.
- R2: Bit 0 of the identification byte is 0 when any enabled cause is pending and 1 otherwise. The interrupt line is the OR of all enabled pending causes, so it always equals the inverse of bit 0.
- R3: Bits 3..1 report the single highest enabled pending cause. Line status (011) has the highest priority. The receive level (010 or 110) comes next, then transmit empty (001), and modem change (000) is lowest. With nothing pending, bits 3..1 read 000.
- R4: A character timeout reports code 110 at the same level as data available. If both are pending, data available (010) is reported.
- R5: Enable bit 0 gates data available and timeout, bit 1 gates transmit empty, bit 2 gates line status and bit 3 gates modem change. A cause that is disabled still stays latched and is reported once its enable bit is set.
- R6: A pulse on any of the four line error/break inputs latches the line cause. A line-status read clears it.
- R7: A receive-buffer read clears both the data-available cause and the timeout cause.
- R8: A holding-register write clears the transmit cause. An identification read also clears it, but only while the byte reports code 001. An identification read while a higher cause is reported leaves the transmit cause pending.
- R9: The delta bits are: bit 0 for any change of CTS, bit 1 for any change of DSR, bit 2 for a falling (trailing) edge of the ring indicator, and bit 3 for any change of carrier detect. A rising ring edge sets nothing. A modem-status read clears all four bits.
- R10: Bits 7..6 of the identification byte read 11 while the FIFO-enable input is high and 00 otherwise. Bits 5..4 always read 00.
- R11: If a cause's set event and its clearing access fall in the same cycle, the cause stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ier_i | input | 4 | Cause enables: [0] receive/timeout, [1] transmit empty, [2] line status, [3] modem change |
| fifo_en_i | input | 1 | FIFO mode indication, reflected in identification bits 7..6 |
| line_err_i | input | 4 | One-cycle pulses for overrun, parity, framing and break |
| rx_avail_set_i | input | 1 | Pulse: received data became available |
| rx_tmo_set_i | input | 1 | Pulse: receive character timeout expired |
| thr_empty_set_i | input | 1 | Pulse: holding register became empty |
| iir_rd_i | input | 1 | Host read strobe of the identification byte |
| lsr_rd_i | input | 1 | Host read strobe of the line status register |
| rbr_rd_i | input | 1 | Host read strobe of the receive buffer |
| msr_rd_i | input | 1 | Host read strobe of the modem status register |
| thr_wr_i | input | 1 | Host write strobe of the holding register |
| modem_i | input | 4 | Modem pin levels, asserted high: [0] CTS, [1] DSR, [2] RI, [3] DCD |
| iir_o | output | 8 | Identification byte |
| irq_o | output | 1 | Interrupt line, active high |
| modem_delta_o | output | 4 | Captured delta bits for the modem status read |

## Verification
Every event pulse, clearing strobe and modem pin change is sampled at a rising edge. Its effect on the identification byte, the interrupt line and the delta bits is visible right after that same edge. The enable word and the FIFO-enable input act combinationally, in the cycle they are applied. The bench changes inputs only at falling edges and samples outputs 2 ns after the rising edge that follows. Each vector is therefore checked exactly one edge after it is applied, while its levels are still held. The identification-read clearing of the transmit cause is checked against the code shown before that edge and not after it.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int unsigned IER_W   = 4;
  localparam int unsigned MODEM_W = 4;
  localparam int unsigned SRC_N   = 4;

  // latched cause vector positions
  localparam int unsigned S_LINE = 0;
  localparam int unsigned S_RDA  = 1;
  localparam int unsigned S_TMO  = 2;
  localparam int unsigned S_THRE = 3;

  // enable word positions
  localparam int unsigned E_RX    = 0;
  localparam int unsigned E_THRE  = 1;
  localparam int unsigned E_LINE  = 2;
  localparam int unsigned E_MODEM = 3;

  // modem pin positions
  localparam int unsigned M_CTS = 0;
  localparam int unsigned M_DSR = 1;
  localparam int unsigned M_RI  = 2;
  localparam int unsigned M_DCD = 3;

  typedef enum logic [2:0] {
    ID_MODEM = 3'b000,
    ID_THRE  = 3'b001,
    ID_RDA   = 3'b010,
    ID_LINE  = 3'b011,
    ID_TMO   = 3'b110
  } irq_id_e;

  typedef struct packed {
    logic line;
    logic rda;
    logic tmo;
    logic thre;
    logic modem;
  } pend_t;

endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q;

  // a set in the same cycle as a clear wins, so no event is lost
  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q[g] <= 1'b0;
      else if (set_i[g])  q[g] <= 1'b1;
      else if (clr_i[g])  q[g] <= 1'b0;
    end

    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> q[g]);
  end

  assign q_o = q;

endmodule

// File: rtl/irq_modem_delta.sv
module irq_modem_delta
  import uart_irq_pkg::*;
#(
  parameter int unsigned W = MODEM_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_i,
  input  logic         rd_i,
  output logic [W-1:0] delta_o
);

  logic [W-1:0] prev_q;
  logic         primed_q;
  logic [W-1:0] hit;
  logic [W-1:0] delta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= pins_i;
      primed_q <= 1'b1;
    end
  end

  // ring indicator reports only its trailing edge; others report any change
  for (genvar g = 0; g < W; g++) begin : g_det
    if (g == M_RI) begin : g_trail
      assign hit[g] = primed_q & prev_q[g] & ~pins_i[g];
    end else begin : g_any
      assign hit[g] = primed_q & (prev_q[g] ^ pins_i[g]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) delta_q <= '0;
    else        delta_q <= (delta_q & ~{W{rd_i}}) | hit;
  end

  assign delta_o = delta_q;

  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !primed_q) || (rd_i && (pins_i == prev_q)) |=> delta_o == '0);

  a_r9_ri_rise_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && !prev_q[M_RI] && pins_i[M_RI] && rd_i) |=> !delta_o[M_RI]);

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_irq_pkg::*;
(
  input  pend_t   pend_i,
  output irq_id_e code_o,
  output logic    none_o
);

  always_comb begin
    if (pend_i.line)       code_o = ID_LINE;
    else if (pend_i.rda)   code_o = ID_RDA;
    else if (pend_i.tmo)   code_o = ID_TMO;
    else if (pend_i.thre)  code_o = ID_THRE;
    else                   code_o = ID_MODEM;
  end

  assign none_o = ~(pend_i.line | pend_i.rda | pend_i.tmo | pend_i.thre | pend_i.modem);

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int unsigned ERR_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IER_W-1:0]   ier_i,
  input  logic               fifo_en_i,
  input  logic [ERR_W-1:0]   line_err_i,
  input  logic               rx_avail_set_i,
  input  logic               rx_tmo_set_i,
  input  logic               thr_empty_set_i,
  input  logic               iir_rd_i,
  input  logic               lsr_rd_i,
  input  logic               rbr_rd_i,
  input  logic               msr_rd_i,
  input  logic               thr_wr_i,
  input  logic [MODEM_W-1:0] modem_i,
  output logic [7:0]         iir_o,
  output logic               irq_o,
  output logic [MODEM_W-1:0] modem_delta_o
);

  logic [SRC_N-1:0]   src_set;
  logic [SRC_N-1:0]   src_clr;
  logic [SRC_N-1:0]   src_q;
  logic [MODEM_W-1:0] delta;
  pend_t              pend;
  irq_id_e            code;
  logic               none;
  logic               thre_ack;

  always_comb begin
    src_set         = '0;
    src_set[S_LINE] = |line_err_i;
    src_set[S_RDA]  = rx_avail_set_i;
    src_set[S_TMO]  = rx_tmo_set_i;
    src_set[S_THRE] = thr_empty_set_i;
  end

  // identification read acknowledges the transmit cause only when it is shown
  assign thre_ack = iir_rd_i & ~none & (code == ID_THRE);

  always_comb begin
    src_clr         = '0;
    src_clr[S_LINE] = lsr_rd_i;
    src_clr[S_RDA]  = rbr_rd_i;
    src_clr[S_TMO]  = rbr_rd_i;
    src_clr[S_THRE] = thr_wr_i | thre_ack;
  end

  irq_src_latch #(.W(SRC_N)) u_src (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (src_set),
    .clr_i (src_clr),
    .q_o   (src_q)
  );

  irq_modem_delta #(.W(MODEM_W)) u_delta (
    .clk     (clk),
    .rst_n   (rst_n),
    .pins_i  (modem_i),
    .rd_i    (msr_rd_i),
    .delta_o (delta)
  );

  always_comb begin
    pend.line  = src_q[S_LINE] & ier_i[E_LINE];
    pend.rda   = src_q[S_RDA]  & ier_i[E_RX];
    pend.tmo   = src_q[S_TMO]  & ier_i[E_RX];
    pend.thre  = src_q[S_THRE] & ier_i[E_THRE];
    pend.modem = (|delta)      & ier_i[E_MODEM];
  end

  irq_prio_enc u_enc (
    .pend_i (pend),
    .code_o (code),
    .none_o (none)
  );

  assign irq_o         = pend.line | pend.rda | pend.tmo | pend.thre | pend.modem;
  assign iir_o         = {{2{fifo_en_i}}, 2'b00, code, none};
  assign modem_delta_o = delta;

  a_r2_line_vs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == ~iir_o[0]);

  a_r3_line_first: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q[S_LINE] && ier_i[E_LINE]) |-> iir_o[3:1] == 3'b011);

  a_r6_lsr_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd_i && line_err_i == '0) |=> !src_q[S_LINE]);

  a_r7_rbr_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rbr_rd_i && !rx_avail_set_i && !rx_tmo_set_i) |=> !src_q[S_RDA] && !src_q[S_TMO]);

  a_r8_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr_i && !thr_empty_set_i) |=> !src_q[S_THRE]);

  a_r8_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd_i && src_q[S_THRE] && iir_o[3:1] != 3'b001) |=> src_q[S_THRE]);

endmodule

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ier = '0;
  logic       fifo_en = 1'b0;
  logic [3:0] line_err = '0;
  logic       rx_set = 1'b0, tmo_set = 1'b0, thre_set = 1'b0;
  logic       iir_rd = 1'b0, lsr_rd = 1'b0, rbr_rd = 1'b0, msr_rd = 1'b0, thr_wr = 1'b0;
  logic [3:0] modem = '0;
  logic [7:0] iir;
  logic       irq;
  logic [3:0] delta;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  uart_irq_ident u_uart_irq_ident (
    .clk             (clk),
    .rst_n           (rst_n),
    .ier_i           (ier),
    .fifo_en_i       (fifo_en),
    .line_err_i      (line_err),
    .rx_avail_set_i  (rx_set),
    .rx_tmo_set_i    (tmo_set),
    .thr_empty_set_i (thre_set),
    .iir_rd_i        (iir_rd),
    .lsr_rd_i        (lsr_rd),
    .rbr_rd_i        (rbr_rd),
    .msr_rd_i        (msr_rd),
    .thr_wr_i        (thr_wr),
    .modem_i         (modem),
    .iir_o           (iir),
    .irq_o           (irq),
    .modem_delta_o   (delta)
  );

  // vector: [23:20] enables, [19:16] line errors, [15] rx, [14] timeout,
  // [13] thre set, [12] lsr read, [11] rbr read, [10] iir read, [9] thr write,
  // [8:1] expected identification byte, [0] expected interrupt line
  localparam int NV = 21;
  localparam logic [23:0] VEC [0:NV-1] = '{
    {4'hF, 4'h0, 7'b0000000, 8'h01, 1'b0},  // R1 idle
    {4'hF, 4'h0, 7'b0010000, 8'h02, 1'b1},  // R3 thre
    {4'hF, 4'h0, 7'b1000000, 8'h04, 1'b1},  // R3 rda over thre
    {4'hF, 4'h1, 7'b0000000, 8'h06, 1'b1},  // R6 line over all
    {4'hF, 4'h0, 7'b0001000, 8'h04, 1'b1},  // R6 lsr read
    {4'hF, 4'h0, 7'b0000100, 8'h02, 1'b1},  // R7 rbr read
    {4'hF, 4'h0, 7'b0000010, 8'h01, 1'b0},  // R8 iir read on thre
    {4'hF, 4'h0, 7'b0100000, 8'h0C, 1'b1},  // R4 timeout
    {4'hF, 4'h0, 7'b0010000, 8'h0C, 1'b1},  // R3 timeout over thre
    {4'hF, 4'h0, 7'b0000010, 8'h0C, 1'b1},  // R8 iir read shows timeout
    {4'hF, 4'h0, 7'b0000100, 8'h02, 1'b1},  // R7 thre kept
    {4'hF, 4'h0, 7'b0000001, 8'h01, 1'b0},  // R8 thr write
    {4'h0, 4'h0, 7'b1000000, 8'h01, 1'b0},  // R5 disabled rda
    {4'h1, 4'h0, 7'b0000000, 8'h04, 1'b1},  // R5 enable later
    {4'h1, 4'h0, 7'b1000100, 8'h04, 1'b1},  // R11 set and read together
    {4'h1, 4'h0, 7'b0000100, 8'h01, 1'b0},  // R7 cleared
    {4'hB, 4'h8, 7'b0000000, 8'h01, 1'b0},  // R5 line disabled
    {4'hF, 4'h0, 7'b0000000, 8'h06, 1'b1},  // R5 line enabled
    {4'hF, 4'h0, 7'b0001000, 8'h01, 1'b0},  // R6 cleared
    {4'hF, 4'h4, 7'b0000000, 8'h06, 1'b1},  // R6 framing bit
    {4'hF, 4'h0, 7'b0001000, 8'h01, 1'b0}   // R6 cleared
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_strobes();
    line_err = '0; rx_set = 0; tmo_set = 0; thre_set = 0;
    iir_rd = 0; lsr_rd = 0; rbr_rd = 0; msr_rd = 0; thr_wr = 0;
  endtask

  // apply at falling edge, sample 2 ns after the next rising edge
  task automatic settle();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    @(negedge clk);
    clear_strobes();
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    modem = 4'b0101;                 // levels present during reset
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset iir", iir, 8'h01);
    chk("R1 reset irq", irq, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    ier = 4'hF;
    settle();
    settle();
    chk("R1 no delta from reset levels", delta, 4'h0);
    chk("R1 idle iir", iir, 8'h01);
    @(negedge clk);
    modem = 4'b0000;
    settle();
    chk("R9 cts and ri fall", delta, 4'b0101);
    @(negedge clk);
    msr_rd = 1;
    settle();
    chk("R9 msr read clears", delta, 4'h0);
    idle();

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ier      = VEC[i][23:20];
      line_err = VEC[i][19:16];
      rx_set   = VEC[i][15];
      tmo_set  = VEC[i][14];
      thre_set = VEC[i][13];
      lsr_rd   = VEC[i][12];
      rbr_rd   = VEC[i][11];
      iir_rd   = VEC[i][10];
      thr_wr   = VEC[i][9];
      settle();
      chk($sformatf("R3 vector %0d iir", i), iir, VEC[i][8:1]);
      chk($sformatf("R2 vector %0d irq", i), irq, VEC[i][0]);
    end
    idle();

    // modem deltas
    ier = 4'hF;
    @(negedge clk); modem = 4'b0001; settle();
    chk("R9 cts delta", delta, 4'b0001);
    chk("R3 modem code", iir, 8'h00);
    chk("R2 modem irq", irq, 1'b1);
    @(negedge clk); msr_rd = 1; settle();
    chk("R9 cleared iir", iir, 8'h01);
    idle();
    @(negedge clk); modem = 4'b0011; settle();
    chk("R9 dsr delta", delta, 4'b0010);
    @(negedge clk); msr_rd = 1; settle();
    idle();
    @(negedge clk); modem = 4'b0111; settle();
    chk("R9 ri rise ignored", delta, 4'b0000);
    chk("R9 ri rise no irq", irq, 1'b0);
    @(negedge clk); modem = 4'b0011; settle();
    chk("R9 ri trailing edge", delta, 4'b0100);
    @(negedge clk); modem = 4'b1011; settle();
    chk("R9 dcd accumulates", delta, 4'b1100);
    @(negedge clk); thre_set = 1; settle();
    chk("R3 thre over modem", iir, 8'h02);
    idle();
    fifo_en = 1'b1;
    #2;
    chk("R10 fifo bits", iir, 8'hC2);
    @(negedge clk); thr_wr = 1; settle();
    chk("R8 write leaves modem", iir, 8'hC0);
    @(negedge clk); thr_wr = 0; msr_rd = 1; settle();
    chk("R10 none pending fifo", iir, 8'hC1);
    chk("R2 irq low", irq, 1'b0);
    idle();
    @(negedge clk); modem = 4'b1010; msr_rd = 1; settle();
    chk("R11 delta set beats read", delta, 4'b0001);
    idle();
    @(negedge clk);
    ier = 4'h7;
    #2;
    chk("R5 modem masked", irq, 1'b0);
    chk("R5 modem still latched", delta, 4'b0001);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule